// File: doc/BRIEF.md
# Retriggerable Gated One-Shot

This block turns a qualifying trigger transition into a single high pulse on `pulse_o` whose length is a whole number of clock cycles. Two gate inputs of opposite polarity form the trigger: the trigger condition is "`gate_low_n` low and `gate_high` high". A pulse begins only when that condition becomes true. It can become true in two ways: `gate_low_n` falls while `gate_high` is high, or `gate_high` rises while `gate_low_n` is low.

The length is read from `width` at the moment a trigger is accepted. A new trigger during a live pulse reloads the length, so the pulse runs one full programmed length past the latest trigger. An active-low clear holds the output low and cuts a live pulse short.

All three control inputs may be asynchronous to `clk`. Each passes through a synchroniser chain before any decision is made, so the output responds a fixed number of cycles after an input changes.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the pulse count is cleared and `pulse_o` is low after that edge; a reset during a live pulse ends it.
- R2: With `gate_high` held high, a fall of `gate_low_n` applied before rising edge k sets `pulse_o` high after edge k+2 (two synchroniser stages plus one load stage).
- R3: With `gate_low_n` held low, a rise of `gate_high` starts a pulse with the same latency as R2.
- R4: A pulse started with `width` = N (1 to 2^DUR_W-1) stays high for exactly N consecutive cycles, including N = 255 at the default width.
- R5: A fresh trigger during a live pulse reloads the count from `width`, so `pulse_o` stays high until N cycles after the reload. The fresh trigger means the condition goes false, then true again.
- R6: Steady levels never start a pulse. Holding the trigger condition true after a pulse ends gives no second pulse. Toggling one gate while the other blocks the condition gives no pulse.
- R7: Once `clear_n` has been low at two consecutive rising edges, `pulse_o` is low from the next edge. A pulse cut this way does not resume when `clear_n` returns high.
- R8: A trigger transition that arrives while the synchronised clear is low is discarded. Releasing `clear_n` while the condition is still true does not start a pulse.
- R9: A trigger accepted while `width` is zero has no effect: it starts no pulse from idle and leaves a live pulse's count untouched.
- R10: `width` is sampled only at an accepted trigger; changing it during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_low_n | input | 1 | Trigger gate, qualifies when low; asynchronous |
| gate_high | input | 1 | Trigger gate, qualifies when high; asynchronous |
| clear_n | input | 1 | Clear, active low; asynchronous |
| width | input | DUR_W | Pulse length in cycles, sampled at a trigger |
| pulse_o | output | 1 | One-shot output |

## Verification
The only state in the block is the down-counter, the edge-detect register and the synchroniser chains, and every error in them surfaces on `pulse_o` within a pulse length. A wrong decrement or a missed reload moves the falling edge of the pulse. A wrong edge-detect register either produces a spurious pulse three cycles after a steady level appears or drops a real one. A wrong clear path leaves the output high past the second clock edge after `clear_n` falls. The bench therefore records, for each scenario, the first high cycle, the last high cycle and the count of high cycles, and compares all three with values worked out from the latency rules above.

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
  parameter int DUR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_low_n,
  input  logic             gate_high,
  input  logic             clear_n,
  input  logic [DUR_W-1:0] width,
  output logic             pulse_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] lo_sh, hi_sh, clr_sh;
  logic                   cond_q;
  logic [DUR_W-1:0]       cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_sh  <= '1;
      hi_sh  <= '0;
      clr_sh <= '0;
    end else begin
      lo_sh  <= {lo_sh[TOP-1:0], gate_low_n};
      hi_sh  <= {hi_sh[TOP-1:0], gate_high};
      clr_sh <= {clr_sh[TOP-1:0], clear_n};
    end
  end

  wire clr_s = clr_sh[TOP];
  wire cond  = ~lo_sh[TOP] & hi_sh[TOP];
  wire fire  = cond & ~cond_q & clr_s & (width != '0);

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond;
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_s) cnt <= '0;
    else if (fire)     cnt <= width;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign pulse_o = (cnt != '0) & clr_s;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
  parameter int DUR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_n,
  input logic [DUR_W-1:0] width,
  input logic             pulse_o,
  input logic             clr_s,
  input logic             fire,
  input logic [DUR_W-1:0] cnt
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!pulse_o && cnt == '0));

  a_r2_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(fire));

  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !fire && clr_s) |=> cnt == DUR_W'($past(cnt) - 1'b1));

  a_r7_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && $past(!clear_n)) |=> !pulse_o);

  a_r9_zero_ignored: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && clr_s && width == '0) |=> !pulse_o);

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst(rst), .clear_n(clear_n), .width(width),
  .pulse_o(pulse_o), .clr_s(clr_s), .fire(fire), .cnt(cnt)
);

// File: tb/retrig_oneshot_test.sv
module retrig_oneshot_test;
  localparam int PERIOD = 10;
  localparam int DUR_W  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic gate_low_n = 1'b1, gate_high = 1'b1, clear_n = 1'b1;
  logic [DUR_W-1:0] width = '0;
  logic pulse_o;

  int checks = 0, errors = 0;
  int first_hi, last_hi, n_hi;
  bit done = 0;

  retrig_oneshot #(.DUR_W(DUR_W)) uut (
    .clk(clk), .rst(rst), .gate_low_n(gate_low_n), .gate_high(gate_high),
    .clear_n(clear_n), .width(width), .pulse_o(pulse_o)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sample(input int n);
    first_hi = -1; last_hi = -1; n_hi = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (pulse_o) begin
        if (first_hi < 0) first_hi = k;
        last_hi = k;
        n_hi++;
      end
    end
  endtask

  task automatic expect_pulse(input string tag, input int f, input int l, input int t);
    check(tag, "first high cycle", first_hi, f);
    check(tag, "last high cycle", last_hi, l);
    check(tag, "high cycle count", n_hi, t);
  endtask

  task automatic idle(input int n);
    gate_low_n = 1'b1; gate_high = 1'b1; clear_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", "pulse in reset", pulse_o, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "pulse after reset", pulse_o, 0);
  endtask

  task automatic t_low_gate;
    width = 5;
    @(negedge clk);
    fork
      sample(40);
      gate_low_n = 1'b0;
    join
    expect_pulse("R2", 3, 7, 5);
    check("R6", "no pulse from held condition", n_hi, 5);
    idle(6);
  endtask

  task automatic t_high_gate;
    gate_high = 1'b0; repeat (3) @(negedge clk);
    gate_low_n = 1'b0; repeat (4) @(negedge clk);
    width = 7;
    fork
      sample(30);
      gate_high = 1'b1;
    join
    expect_pulse("R3", 3, 9, 7);
    idle(6);
  endtask

  task automatic t_blocked_toggle;
    @(negedge clk);
    fork
      sample(50);
      begin
        for (int i = 0; i < 4; i++) begin
          gate_high = 1'b0; repeat (3) @(negedge clk);
          gate_high = 1'b1; repeat (3) @(negedge clk);
        end
        gate_high = 1'b0;
        for (int i = 0; i < 3; i++) begin
          gate_low_n = 1'b0; repeat (3) @(negedge clk);
          gate_low_n = 1'b1; repeat (3) @(negedge clk);
        end
        gate_high = 1'b1;
      end
    join
    check("R6", "pulses from blocked toggling", n_hi, 0);
    idle(4);
  endtask

  task automatic t_retrig(input int d1, input int d2);
    width = DUR_W'(d1);
    @(negedge clk);
    fork
      sample(50);
      begin
        gate_low_n = 1'b0;
        repeat (6) @(negedge clk);
        gate_low_n = 1'b1;
        @(negedge clk);
        width = DUR_W'(d2);
        gate_low_n = 1'b0;
      end
    join
    expect_pulse("R5", 3, 9 + d2, 7 + d2);
    idle(6);
  endtask

  task automatic t_width_hold;
    width = 6;
    @(negedge clk);
    fork
      sample(40);
      begin
        gate_low_n = 1'b0;
        repeat (4) @(negedge clk);
        width = 20;
      end
    join
    expect_pulse("R10", 3, 8, 6);
    idle(6);
  endtask

  task automatic t_clear;
    width = 20;
    @(negedge clk);
    fork
      sample(40);
      begin
        gate_low_n = 1'b0;
        repeat (6) @(negedge clk);
        clear_n = 1'b0;
        repeat (6) @(negedge clk);
        clear_n = 1'b1;
      end
    join
    expect_pulse("R7", 3, 7, 5);
    idle(6);
  endtask

  task automatic t_trigger_in_clear;
    clear_n = 1'b0;
    repeat (4) @(negedge clk);
    width = 5;
    fork
      sample(30);
      begin
        gate_low_n = 1'b0;
        repeat (8) @(negedge clk);
        clear_n = 1'b1;
      end
    join
    check("R8", "pulses with trigger under clear", n_hi, 0);
    idle(6);
  endtask

  task automatic t_zero;
    width = 0;
    @(negedge clk);
    fork
      sample(20);
      gate_low_n = 1'b0;
    join
    check("R9", "pulses from zero width", n_hi, 0);
    idle(6);
    width = 8;
    fork
      sample(30);
      begin
        gate_low_n = 1'b0;
        repeat (5) @(negedge clk);
        gate_low_n = 1'b1;
        width = 0;
        @(negedge clk);
        gate_low_n = 1'b0;
      end
    join
    expect_pulse("R9", 3, 10, 8);
    idle(6);
  endtask

  task automatic t_reset_mid;
    width = 20;
    @(negedge clk);
    fork
      sample(30);
      begin
        gate_low_n = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        gate_low_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
      end
    join
    expect_pulse("R1", 3, 6, 4);
    idle(6);
  endtask

  task automatic t_max;
    width = '1;
    @(negedge clk);
    fork
      sample(270);
      gate_low_n = 1'b0;
    join
    expect_pulse("R4", 3, 257, 255);
    idle(6);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    idle(4);
    t_low_gate();
    t_high_gate();
    t_blocked_toggle();
    t_retrig(10, 10);
    t_retrig(10, 4);
    t_width_hold();
    t_clear();
    t_trigger_in_clear();
    t_zero();
    t_reset_mid();
    t_max();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule